// File: doc/BRIEF.md
# Reservation Monitor for Load-Locked / Store-Conditional Pairs

This block keeps the reservation state that pairs a load-locked operation with a later store-conditional in a simple in-order memory pipeline. It watches a stream of decoded memory operations, at most one per clock, each marked by a valid strobe. Each operation carries a class code, a byte address and a flag that says whether its destination is the hardwired zero register. The block holds one lock flag and one locked address. For every conditional store it reports pass or fail.

A load-locked operation opens a reservation on an aligned quadword. Ordinary loads and stores close the reservation. So does an unaligned load with a live destination, and so does any unaligned store. Privileged loads and stores, cache-block evicts and write-hint operations do not touch the reservation. An ordinary store-conditional consumes the reservation. The privileged conditional store is checked against the reservation but leaves it in place. Coherence invalidations, the memory system and the store data are handled elsewhere.

Top module: `llsc_monitor`

## Requirements
- R1: A synchronous active-high reset clears the lock flag. A store-conditional issued before any load-locked therefore reports fail.
- R2: A load-locked (class 5) or privileged load-locked (class 12) sets the lock flag and records its address. This replaces any earlier reservation.
- R3: A conditional store passes only if the lock flag is set and bits [ADDR_W-1:3] of its address equal those of the locked address. Address bits [2:0] are not compared.
- R4: An ordinary load (class 1) or ordinary store (class 2) clears the lock flag, whatever its address.
- R5: An unaligned load (class 3) clears the lock flag only when its zero-destination flag is 0. An unaligned store (class 4) always clears it.
- R6: Privileged load (class 7), privileged store (class 8), cache-block evict (class 10), write-hint (class 11) and the unused codes 0, 13, 14 and 15 leave both the lock flag and the locked address unchanged.
- R7: An ordinary store-conditional (class 6) clears the lock flag after it is evaluated, whether it passed or failed.
- R8: A privileged conditional store (class 9) is evaluated like R3 but leaves the lock flag and the locked address unchanged.
- R9: `resValid` is high for exactly one cycle, in the cycle after a conditional store (class 6 or 9) is presented with `opValid` high. It is low at every other time, and `resPass` is 0 whenever `resValid` is 0.
- R10: While `opValid` is low, the class, address and flag inputs have no effect on the reservation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| opValid | input | 1 | An operation is presented this cycle |
| opClass | input | 4 | Operation class code |
| opAddr | input | ADDR_W | Byte address of the operation |
| opDstZero | input | 1 | Destination is the hardwired zero register |
| resValid | output | 1 | Conditional-store result is present |
| resPass | output | 1 | 1 = conditional store succeeded |

## Verification
The bench targets the cases that differ in small ways. An unaligned load with the zero destination must spare the reservation; a design that treated it as an ordinary load would fail the following store-conditional. Several operations must leave the reservation alone: the privileged conditional store, the evict, the write-hint and the privileged store. A design that cleared the flag on any of them would report fail where pass is due. Two addresses that differ only in bits [2:0] must match, and a second load-locked must replace the first reservation. Comparing the low bits, or keeping the old address, shows up as a wrong pass/fail. Random sequences from a small address pool check every result against a reference model.

// File: rtl/llsc_pkg.sv
package llsc_pkg;

  typedef enum logic [3:0] {
    CLS_NONE       = 4'd0,
    CLS_LOAD       = 4'd1,
    CLS_STORE      = 4'd2,
    CLS_LOAD_UNAL  = 4'd3,
    CLS_STORE_UNAL = 4'd4,
    CLS_LOAD_LOCK  = 4'd5,
    CLS_STORE_COND = 4'd6,
    CLS_PRIV_LOAD  = 4'd7,
    CLS_PRIV_STORE = 4'd8,
    CLS_PRIV_COND  = 4'd9,
    CLS_EVICT      = 4'd10,
    CLS_WRITE_HINT = 4'd11,
    CLS_PRIV_LOCK  = 4'd12
  } opClassE;

  // Strobes from control to datapath
  typedef struct packed {
    logic captureLock;  // open a reservation at the current address
    logic dropLock;     // clear the lock flag after this cycle
    logic checkCond;    // evaluate a conditional store
  } lockStrobeS;

endpackage

// File: rtl/llsc_ctrl.sv
module llsc_ctrl
  import llsc_pkg::*;
(
  input  logic       opValid,
  input  logic [3:0] opClass,
  input  logic       opDstZero,
  output lockStrobeS strobes
);

  opClassE cls;
  assign cls = opClassE'(opClass);

  always_comb begin
    strobes = '0;
    if (opValid) begin
      case (cls)
        CLS_LOAD, CLS_STORE, CLS_STORE_UNAL: strobes.dropLock = 1'b1;
        CLS_LOAD_UNAL:                       strobes.dropLock = !opDstZero;
        CLS_LOAD_LOCK, CLS_PRIV_LOCK:        strobes.captureLock = 1'b1;
        CLS_STORE_COND: begin
          strobes.checkCond = 1'b1;
          strobes.dropLock  = 1'b1;
        end
        CLS_PRIV_COND:                       strobes.checkCond = 1'b1;
        default:                             strobes = '0;
      endcase
    end
  end

  // A single op never both opens and evaluates or clears a reservation
  always_comb begin
    p_strobe_exclusive_r2: assert (!(strobes.captureLock && (strobes.dropLock || strobes.checkCond)))
      else $error("capture strobe combined with drop or check");
  end

endmodule

// File: rtl/llsc_datapath.sv
module llsc_datapath
  import llsc_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int OFFSET_BITS = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  lockStrobeS        strobes,
  input  logic [ADDR_W-1:0] opAddr,
  output logic              lockHeld,
  output logic [ADDR_W-1:0] lockAddr,
  output logic              resValid,
  output logic              resPass
);

  localparam logic [ADDR_W-1:0] TAG_MASK = {ADDR_W{1'b1}} << OFFSET_BITS;

  logic tagMatch;
  assign tagMatch = ((opAddr & TAG_MASK) == (lockAddr & TAG_MASK));

  always_ff @(posedge clk) begin
    if (rst) begin
      lockHeld <= 1'b0;
      lockAddr <= '0;
    end else if (strobes.captureLock) begin
      lockHeld <= 1'b1;
      lockAddr <= opAddr;
    end else if (strobes.dropLock) begin
      lockHeld <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      resValid <= 1'b0;
      resPass  <= 1'b0;
    end else begin
      resValid <= strobes.checkCond;
      resPass  <= strobes.checkCond && lockHeld && tagMatch;
    end
  end

  p_pass_needs_valid_r9: assert property (@(posedge clk) disable iff (rst)
    resPass |-> resValid);

  p_no_pass_unlocked_r3: assert property (@(posedge clk) disable iff (rst)
    (strobes.checkCond && !lockHeld) |=> !resPass);

endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
  import llsc_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int OFFSET_BITS = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              opValid,
  input  logic [3:0]        opClass,
  input  logic [ADDR_W-1:0] opAddr,
  input  logic              opDstZero,
  output logic              resValid,
  output logic              resPass
);

  lockStrobeS        strobes;
  logic              lockHeld;
  logic [ADDR_W-1:0] lockAddr;

  llsc_ctrl ctrl_i (
    .opValid  (opValid),
    .opClass  (opClass),
    .opDstZero(opDstZero),
    .strobes  (strobes)
  );

  llsc_datapath #(.ADDR_W(ADDR_W), .OFFSET_BITS(OFFSET_BITS)) dp_i (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .opAddr  (opAddr),
    .lockHeld(lockHeld),
    .lockAddr(lockAddr),
    .resValid(resValid),
    .resPass (resPass)
  );

  logic isCond, isQuiet;
  assign isCond  = (opClass == 4'd6) || (opClass == 4'd9);
  assign isQuiet = (opClass == 4'd7) || (opClass == 4'd8) ||
                   (opClass == 4'd10) || (opClass == 4'd11);

  p_result_follows_cond_r9: assert property (@(posedge clk) disable iff (rst)
    (opValid && isCond) |=> resValid);

  p_no_spurious_result_r9: assert property (@(posedge clk) disable iff (rst)
    !(opValid && isCond) |=> !resValid);

  p_lock_sets_r2: assert property (@(posedge clk) disable iff (rst)
    (opValid && (opClass == 4'd5 || opClass == 4'd12)) |=> lockHeld);

  p_plain_clears_r4: assert property (@(posedge clk) disable iff (rst)
    (opValid && (opClass == 4'd1 || opClass == 4'd2)) |=> !lockHeld);

  p_unal_zero_keeps_r5: assert property (@(posedge clk) disable iff (rst)
    (opValid && opClass == 4'd3 && opDstZero) |=> $stable(lockHeld));

  p_quiet_keeps_r6: assert property (@(posedge clk) disable iff (rst)
    (opValid && isQuiet) |=> ($stable(lockHeld) && $stable(lockAddr)));

  p_cond_clears_r7: assert property (@(posedge clk) disable iff (rst)
    (opValid && opClass == 4'd6) |=> !lockHeld);

  p_priv_cond_keeps_r8: assert property (@(posedge clk) disable iff (rst)
    (opValid && opClass == 4'd9) |=> ($stable(lockHeld) && $stable(lockAddr)));

  p_idle_keeps_r10: assert property (@(posedge clk) disable iff (rst)
    !opValid |=> ($stable(lockHeld) && $stable(lockAddr)));

endmodule

// File: tb/llsc_monitor_tb.sv
module llsc_monitor_tb_top;

  localparam int ADDR_W = 32;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              opValid = 1'b0;
  logic [3:0]        opClass = '0;
  logic [ADDR_W-1:0] opAddr = '0;
  logic              opDstZero = 1'b0;
  logic              resValid, resPass;

  int nChecks = 0;
  int nFails  = 0;

  // Reference model state
  bit                mHeld = 1'b0;
  logic [ADDR_W-1:0] mAddr = '0;

  always #2.5 clk = ~clk;

  llsc_monitor #(.ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rst(rst), .opValid(opValid), .opClass(opClass),
    .opAddr(opAddr), .opDstZero(opDstZero),
    .resValid(resValid), .resPass(resPass)
  );

  function automatic bit expPass(logic [ADDR_W-1:0] a);
    return mHeld && (a[ADDR_W-1:3] == mAddr[ADDR_W-1:3]);
  endfunction

  function automatic bit clearsLock(logic [3:0] c, bit dz);
    return (c == 4'd1) || (c == 4'd2) || (c == 4'd4) || (c == 4'd6) ||
           (c == 4'd3 && !dz);
  endfunction

  function automatic string reqOf(logic [3:0] c);
    case (c)
      4'd6:    return "R7";
      4'd9:    return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check(bit actual, bit expected, string req);
    nChecks++;
    if (actual !== expected) begin
      nFails++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", req, actual, expected, $time);
    end
  endtask

  // Present one op at a falling edge, check the result one cycle later
  task automatic doOp(bit v, logic [3:0] c, logic [ADDR_W-1:0] a, bit dz, string req);
    bit cond, ePass;
    @(negedge clk);
    opValid = v; opClass = c; opAddr = a; opDstZero = dz;
    cond  = v && (c == 4'd6 || c == 4'd9);
    ePass = cond && expPass(a);
    if (v) begin
      if (c == 4'd5 || c == 4'd12) begin mHeld = 1'b1; mAddr = a; end
      else if (clearsLock(c, dz)) mHeld = 1'b0;
    end
    @(negedge clk);
    opValid = 1'b0;
    check(resValid, cond, (req == "") ? reqOf(c) : req);
    check(resPass, ePass, (req == "") ? "R3" : req);
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [ADDR_W-1:0] pool [4];
    void'($urandom(32'd20240611));
    pool[0] = 32'h0000_1000; pool[1] = 32'h0000_1008;
    pool[2] = 32'h8000_2040; pool[3] = 32'h0000_1010;

    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    check(resValid, 1'b0, "R1");
    check(resPass, 1'b0, "R1");

    // R1: no reservation after reset
    doOp(1, 4'd6, 32'h100, 0, "R1");
    // R2/R3: basic pass, low bits ignored
    doOp(1, 4'd5, 32'h1003, 0, "R2");
    doOp(1, 4'd6, 32'h1005, 0, "R3");
    // R7: consumed after pass
    doOp(1, 4'd6, 32'h1000, 0, "R7");
    // R3: mismatched quadword fails; R7 consumed after fail
    doOp(1, 4'd5, 32'h1000, 0, "R2");
    doOp(1, 4'd6, 32'h1008, 0, "R3");
    doOp(1, 4'd6, 32'h1000, 0, "R7");
    // R2: second load-locked overrides first
    doOp(1, 4'd5, 32'h1000, 0, "R2");
    doOp(1, 4'd12, 32'h2000, 0, "R2");
    doOp(1, 4'd6, 32'h1000, 0, "R2");
    // R4: ordinary store at other address clears
    doOp(1, 4'd5, 32'h1000, 0, "R2");
    doOp(1, 4'd2, 32'h9990, 0, "R4");
    doOp(1, 4'd6, 32'h1000, 0, "R4");
    // R5: unaligned load with zero destination spares lock
    doOp(1, 4'd5, 32'h1000, 0, "R2");
    doOp(1, 4'd3, 32'h1000, 1, "R5");
    doOp(1, 4'd9, 32'h1000, 0, "R5");
    doOp(1, 4'd3, 32'h1000, 0, "R5");
    doOp(1, 4'd6, 32'h1000, 0, "R5");
    doOp(1, 4'd5, 32'h1000, 0, "R2");
    doOp(1, 4'd4, 32'h4000, 1, "R5");
    doOp(1, 4'd6, 32'h1000, 0, "R5");
    // R6: quiet ops keep reservation; R8: privileged conditional keeps it
    doOp(1, 4'd5, 32'h1000, 0, "R2");
    doOp(1, 4'd7, 32'h1000, 0, "R6");
    doOp(1, 4'd8, 32'h3000, 0, "R6");
    doOp(1, 4'd10, 32'h1000, 0, "R6");
    doOp(1, 4'd11, 32'h1000, 0, "R6");
    doOp(1, 4'd0, 32'h1000, 0, "R6");
    doOp(1, 4'd9, 32'h1000, 0, "R8");
    doOp(1, 4'd9, 32'h1000, 0, "R8");
    doOp(1, 4'd6, 32'h1000, 0, "R8");
    // R10: invalid ops ignored
    doOp(1, 4'd5, 32'h1000, 0, "R2");
    doOp(0, 4'd2, 32'h1000, 0, "R10");
    doOp(0, 4'd5, 32'h7000, 0, "R10");
    doOp(0, 4'd6, 32'h1000, 0, "R10");
    doOp(1, 4'd6, 32'h1000, 0, "R10");
    // R1: reset clears a live reservation
    doOp(1, 4'd5, 32'h1000, 0, "R2");
    @(negedge clk); rst = 1'b1; mHeld = 1'b0;
    @(negedge clk); rst = 1'b0;
    doOp(1, 4'd6, 32'h1000, 0, "R1");

    // Random mix
    for (int i = 0; i < 3000; i++) begin
      logic [3:0] c;
      logic [ADDR_W-1:0] a;
      int r;
      r = $urandom_range(0, 9);
      c = (r < 3) ? 4'd5 : (r < 5) ? 4'd6 : (r < 6) ? 4'd9 : 4'($urandom_range(0, 15));
      a = pool[$urandom_range(0, 3)] | ADDR_W'($urandom_range(0, 7));
      doOp($urandom_range(0, 7) != 0, c, a, $urandom_range(0, 1) == 1, "");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule